// File: doc/BRIEF.md
# Timer Control Latch with Selectable Set/Clear Priority

This block is the sampled digital decision core of a classic three-comparator timer. Every clock it takes unsigned samples of the trigger, threshold and reset pin voltages, together with a word giving the supply voltage on the same scale. It registers all of them. It compares each registered sample against a reference derived from the supply word and feeds the results into a set/clear state element. That state element drives a push-pull output bit and a discharge-enable bit.

Trigger sets the state, so the output goes high. Threshold clears it, so the output goes low. An active reset pin forces the output low whatever the other two pins are doing. A static mode input decides what happens when trigger and threshold are active in the same cycle: either the trigger wins or the threshold wins. When no condition is active, the state holds. Analog effects, capacitor timing and output drive strength are not part of this block.

All references use truncating integer division of the registered supply word S.

Top module: `timer_ctl_latch`

## Requirements
- R1: The trigger condition is active when the trigger sample is strictly below floor(S/3). With S=4095 this reference is 1365, and with S=3000 it is 1000.
- R2: The threshold condition is active when the threshold sample is strictly above floor(2*S/3). With S=4095 this reference is 2730, and with S=3000 it is 2000.
- R3: The reset condition is active when the reset-pin sample is strictly below floor(7*S/50), which is 0.7 V on a 5 V scale. With S=4095 this reference is 573, and with S=3000 it is 420. An active reset drives out_o to 0 regardless of trigger, threshold and mode.
- R4: With reset inactive, trigger alone makes out_o 1, and threshold alone makes out_o 0.
- R5: With reset inactive and both trigger and threshold active, out_o becomes 0 when trig_wins_i=0 and 1 when trig_wins_i=1.
- R6: With reset, trigger and threshold all inactive, out_o keeps its previous value.
- R7: disch_o is 1 exactly when out_o is 0.
- R8: While rst is high, and on the cycle after it is released, out_o is 0 and disch_o is 1.
- R9: A sample applied before clock edge k affects out_o only after edge k+1, which is a latency of two clocks.
- R10: When a single sample that ramps up while out_o=1 and down while out_o=0 is fed to both trigger and threshold, out_o alternates. Each rise follows a sample below the trigger reference, and each fall follows a sample above the threshold reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| supply_i | input | SMP_W | Supply voltage on the sample scale |
| trig_smp_i | input | SMP_W | Trigger pin sample |
| thr_smp_i | input | SMP_W | Threshold pin sample |
| rstpin_smp_i | input | SMP_W | Reset pin sample |
| trig_wins_i | input | 1 | 1: trigger wins a tie; 0: threshold wins |
| out_o | output | 1 | Push-pull output bit |
| disch_o | output | 1 | Discharge enable, active when out_o is low |

## Verification
Inputs pass through one register stage, and the state element updates on the following edge, so any input change shows on out_o and disch_o two rising edges later. The bench drives inputs on falling edges and waits two falling edges before it samples. Each check therefore lands half a cycle after the edge that loads the result. The R9 check also samples after one falling edge, to confirm the value has not changed early. In the ramp test the bench compares each output transition with the sample it drove two falling edges before.

// File: rtl/timer_pkg.sv
package timer_pkg;
    // indices of the three comparator channels
    localparam int CH_TRIG = 0;
    localparam int CH_THR  = 1;
    localparam int CH_RST  = 2;
    localparam int N_CH    = 3;

    typedef struct packed {
        logic rst;
        logic thr;
        logic trig;
    } hits_t;

    typedef struct packed {
        logic state;
    } core_t;
endpackage

// File: rtl/timer_refgen.sv
module timer_refgen #(
    parameter int SMP_W   = 12,
    parameter int RST_NUM = 7,
    parameter int RST_DEN = 50
) (
    input  logic [SMP_W-1:0] supply,
    output logic [SMP_W-1:0] ref_lo,
    output logic [SMP_W-1:0] ref_hi,
    output logic [SMP_W-1:0] ref_rst
);
    localparam int NUM_W  = $clog2(RST_NUM + 1);
    localparam int PROD_W = SMP_W + NUM_W;

    logic [SMP_W:0]    twice;
    logic [SMP_W:0]    hi_full;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] rst_full;

    always_comb begin
        twice    = {supply, 1'b0};
        hi_full  = twice / (SMP_W+1)'(3);
        prod     = PROD_W'(supply) * PROD_W'(RST_NUM);
        rst_full = prod / PROD_W'(RST_DEN);
        ref_lo   = supply / SMP_W'(3);
        ref_hi   = hi_full[SMP_W-1:0];
        ref_rst  = rst_full[SMP_W-1:0];
    end
endmodule

// File: rtl/timer_cmp.sv
module timer_cmp
    import timer_pkg::*;
#(
    parameter int SMP_W = 12
) (
    input  logic [SMP_W-1:0] smp  [N_CH],
    input  logic [SMP_W-1:0] refs [N_CH],
    output hits_t            hits
);
    // 1: channel fires when sample is below its reference; 0: above
    localparam logic [N_CH-1:0] BELOW = 3'b101;

    logic [N_CH-1:0] hit_vec;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        if (BELOW[c]) begin : g_below
            assign hit_vec[c] = smp[c] < refs[c];
        end else begin : g_above
            assign hit_vec[c] = smp[c] > refs[c];
        end
    end

    always_comb begin
        hits.trig = hit_vec[CH_TRIG];
        hits.thr  = hit_vec[CH_THR];
        hits.rst  = hit_vec[CH_RST];
    end
endmodule

// File: rtl/timer_core.sv
module timer_core
    import timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  hits_t hits,
    input  logic  trig_wins,
    output logic  state
);
    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (hits.rst) begin
            core_d.state = 1'b0;
        end else if (hits.trig && hits.thr) begin
            core_d.state = trig_wins;
        end else if (hits.trig) begin
            core_d.state = 1'b1;
        end else if (hits.thr) begin
            core_d.state = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign state = core_q.state;
endmodule

// File: rtl/timer_ctl_latch.sv
module timer_ctl_latch
    import timer_pkg::*;
#(
    parameter int SMP_W   = 12,
    parameter int RST_NUM = 7,
    parameter int RST_DEN = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] supply_i,
    input  logic [SMP_W-1:0] trig_smp_i,
    input  logic [SMP_W-1:0] thr_smp_i,
    input  logic [SMP_W-1:0] rstpin_smp_i,
    input  logic             trig_wins_i,
    output logic             out_o,
    output logic             disch_o
);
    typedef struct packed {
        logic [SMP_W-1:0] supply;
        logic [SMP_W-1:0] trig;
        logic [SMP_W-1:0] thr;
        logic [SMP_W-1:0] rstpin;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.supply = supply_i;
        smp_d.trig   = trig_smp_i;
        smp_d.thr    = thr_smp_i;
        smp_d.rstpin = rstpin_smp_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    logic [SMP_W-1:0] ref_lo, ref_hi, ref_rst;
    logic [SMP_W-1:0] ch_smp [N_CH];
    logic [SMP_W-1:0] ch_ref [N_CH];
    hits_t            hits;
    logic             state;

    timer_refgen #(
        .SMP_W  (SMP_W),
        .RST_NUM(RST_NUM),
        .RST_DEN(RST_DEN)
    ) i_refgen (
        .supply (smp_q.supply),
        .ref_lo (ref_lo),
        .ref_hi (ref_hi),
        .ref_rst(ref_rst)
    );

    always_comb begin
        ch_smp[CH_TRIG] = smp_q.trig;
        ch_smp[CH_THR]  = smp_q.thr;
        ch_smp[CH_RST]  = smp_q.rstpin;
        ch_ref[CH_TRIG] = ref_lo;
        ch_ref[CH_THR]  = ref_hi;
        ch_ref[CH_RST]  = ref_rst;
    end

    timer_cmp #(.SMP_W(SMP_W)) i_cmp (
        .smp (ch_smp),
        .refs(ch_ref),
        .hits(hits)
    );

    timer_core i_core (
        .clk      (clk),
        .rst      (rst),
        .hits     (hits),
        .trig_wins(trig_wins_i),
        .state    (state)
    );

    // push-pull stage: output follows the state node, discharge is its complement
    assign out_o   = state;
    assign disch_o = ~state;
endmodule

// File: rtl/timer_ctl_chk.sv
module timer_ctl_chk
    import timer_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input hits_t hits,
    input logic  mode,
    input logic  out,
    input logic  disch
);
    assert_reset_low_R3: assert property (@(posedge clk) disable iff (rst)
        hits.rst |=> !out);

    assert_set_R4: assert property (@(posedge clk) disable iff (rst)
        (hits.trig && !hits.thr && !hits.rst) |=> out);

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (hits.thr && !hits.trig && !hits.rst) |=> !out);

    assert_tie_R5: assert property (@(posedge clk) disable iff (rst)
        (hits.thr && hits.trig && !hits.rst) |=> (out == $past(mode)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!hits.thr && !hits.trig && !hits.rst) |=> $stable(out));

    assert_por_R8: assert property (@(posedge clk)
        rst |=> (!out && disch));
endmodule

bind timer_ctl_latch timer_ctl_chk i_chk (
    .clk  (clk),
    .rst  (rst),
    .hits (hits),
    .mode (trig_wins_i),
    .out  (out_o),
    .disch(disch_o)
);

// File: tb/test_timer_ctl_latch.sv
module test_timer_ctl_latch;
    localparam int  W      = 12;
    localparam time PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] supply = 12'd4095;
    logic [W-1:0] trig_s = 12'd3000;
    logic [W-1:0] thr_s  = 12'd100;
    logic [W-1:0] rp_s   = 12'd4095;
    logic         mode   = 1'b0;
    logic         out_o, disch_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    timer_ctl_latch #(.SMP_W(W)) i_timer_ctl_latch (
        .clk         (clk),
        .rst         (rst),
        .supply_i    (supply),
        .trig_smp_i  (trig_s),
        .thr_smp_i   (thr_s),
        .rstpin_smp_i(rp_s),
        .trig_wins_i (mode),
        .out_o       (out_o),
        .disch_o     (disch_o)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // drive on a falling edge, result due two falling edges later
    task automatic drive(int t, int h, int r);
        @(negedge clk);
        trig_s = W'(t);
        thr_s  = W'(h);
        rp_s   = W'(r);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_por();
        chk("R8 out during reset", out_o, 1'b0);
        chk("R8 disch during reset", disch_o, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 out after release", out_o, 1'b0);
        chk("R8 disch after release", disch_o, 1'b1);
    endtask

    task automatic t_sweep();
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int c = 0; c < 8; c++) begin
                    logic tr, th, rs, e;
                    mode = m[0];
                    if (p == 1) drive(100, 100, 4095);
                    else        drive(3000, 4000, 4095);
                    tr = c[0]; th = c[1]; rs = c[2];
                    drive(tr ? 100 : 3000, th ? 4000 : 100, rs ? 0 : 4095);
                    if (rs)            e = 1'b0;
                    else if (tr && th) e = m[0];
                    else if (tr)       e = 1'b1;
                    else if (th)       e = 1'b0;
                    else               e = p[0];
                    if (rs)            chk("R3 reset override", out_o, e);
                    else if (tr && th) chk("R5 tie priority", out_o, e);
                    else if (tr || th) chk("R4 set/clear", out_o, e);
                    else               chk("R6 hold", out_o, e);
                    chk("R7 disch complement", disch_o, ~e);
                end
            end
        end
    endtask

    task automatic t_bounds(int s, int lo, int hi, int rr);
        supply = W'(s);
        mode = 1'b0;
        drive(3000 > hi ? hi : 3000, hi, 4095);
        drive(lo, 100, 4095);
        chk("R1 at trigger ref inactive", out_o, 1'b0);
        drive(lo - 1, 100, 4095);
        chk("R1 below trigger ref active", out_o, 1'b1);
        drive(lo, hi, 4095);
        chk("R2 at threshold ref inactive", out_o, 1'b1);
        drive(lo, hi + 1, 4095);
        chk("R2 above threshold ref active", out_o, 1'b0);
        drive(lo - 1, 100, 4095);
        drive(lo, 100, rr);
        chk("R3 at reset ref inactive", out_o, 1'b1);
        drive(lo, 100, rr - 1);
        chk("R3 below reset ref active", out_o, 1'b0);
        supply = 12'd4095;
    endtask

    task automatic t_latency();
        drive(3000, 4000, 4095);
        @(negedge clk);
        trig_s = 12'd100;
        thr_s  = 12'd100;
        @(negedge clk);
        chk("R9 no change after one edge", out_o, 1'b0);
        @(negedge clk);
        chk("R9 change after two edges", out_o, 1'b1);
    endtask

    task automatic t_astable();
        int v = 2000, h1 = 2000, h2 = 2000, rises = 0, falls = 0;
        logic prev;
        drive(3000, 4000, 4095);
        prev = out_o;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (out_o && !prev) begin
                rises++;
                chk("R10 rise after low crossing", h2 < 1365, 1'b1);
            end
            if (!out_o && prev) begin
                falls++;
                chk("R10 fall after high crossing", h2 > 2730, 1'b1);
            end
            prev = out_o;
            v = out_o ? v + 40 : v - 40;
            trig_s = W'(v);
            thr_s  = W'(v);
            h2 = h1;
            h1 = v;
        end
        chk("R10 enough rises", rises >= 3, 1'b1);
        chk("R10 enough falls", falls >= 3, 1'b1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_por();
        t_sweep();
        t_bounds(4095, 1365, 2730, 573);
        t_bounds(3000, 1000, 2000, 420);
        t_latency();
        t_astable();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule